// File: doc/BRIEF.md
# Serial Receiver with Protected Holding Byte

This block receives asynchronous serial characters from a line that has already been synchronised to the clock. It uses a tick that runs at sixteen times the bit rate. Each character has a start bit, eight data bits sent LSB first, an optional parity bit and one stop bit. A completed character goes into a one-byte holding register. A status register reports whether a byte is waiting and which errors came with it. A single level interrupt tells software that something needs attention.

Error reporting follows a strict order. When a character completes while the held byte is still unread, the held byte is kept and the new character is dropped. The overrun indication, and a break that was seen on a dropped character, stay hidden while software reads the good byte. They appear only after that read, together with a data-available flag that marks a byte software must throw away. They are removed by a further data read, which must come after a status read that has shown the overrun.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset, status_o is 0x00, irq_o is low, the parity mode is "none" and both interrupt enables are off.
- R2: A character with a valid stop bit is assembled LSB first and appears on data_o. Once the stop bit has been sampled, status_o bit 0 (byte available) is set, and a data read (rd_data_i pulse) clears it.
- R3: ctrl_i[3:2] selects the parity check when it is written with ctrl_we_i: 00 or 11 means none, 01 means even, 10 means odd. A mismatch sets status_o bit 4 along with that character.
- R4: A stop bit sampled low sets status_o bit 3 (framing) along with that character.
- R5: A character whose every sample, the stop bit included, is low sets status_o bit 2 (break) and bit 3. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: A start bit that is no longer low at mid-bit returns the receiver to idle, and no character is loaded.
- R7: A character that completes while the held byte is unread does not change data_o. Every later character is dropped until the overrun has been shown.
- R8: While an overrun is pending, status_o bits 1 and 2 stay clear. The data read of the valid byte then makes status_o show bit 0 and bit 1, plus bit 2 if any dropped character was a break. The byte presented after that read is invalid.
- R9: Overrun and break bits are cleared, together with bit 0, only by a data read that follows a status read (rd_stat_i pulse) during which bit 1 was shown. A data read before such a status read changes nothing.
- R10: irq_o is the OR of two terms. The first is bit 0 gated by ctrl_i[0]. The second is the OR of the parity, framing, break and overrun bits and of a hidden pending overrun, gated by ctrl_i[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronised serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| ctrl_we_i | input | 1 | Write strobe for the control bits |
| ctrl_i | input | 4 | [0] data-available enable, [1] error enable, [3:2] parity mode |
| rd_data_i | input | 1 | Data register read strobe |
| rd_stat_i | input | 1 | Status register read strobe |
| data_o | output | 8 | Holding register contents |
| status_o | output | 8 | {3'b0, parity, framing, break, overrun, available} |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong receive sequencer shows up as a wrong byte or as a missing bit 0 half a bit time after the stop bit. A lost overrun or break pending state shows up only one data read later, because status_o then lacks bits 1 or 2. An early release shows up at once, when bits 1 or 2 appear before any data read. A wrong clearing condition leaves status_o at the wrong value on the cycle after a data read.

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DBITS = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             tick16_i,
  input  logic             ctrl_we_i,
  input  logic [3:0]       ctrl_i,
  input  logic             rd_data_i,
  input  logic             rd_stat_i,
  output logic [DBITS-1:0] data_o,
  output logic [7:0]       status_o,
  output logic             irq_o
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DBITS) + 1;
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_t;

  st_t             st_q;
  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   bitn_q;
  logic [DBITS-1:0] sh_q, hold_q;
  logic            allz_q, par_q;
  logic            done_q, fe_n_q, pe_n_q, brk_n_q;
  logic [1:0]      en_q;
  logic [1:0]      pmode_q;
  logic            avail_q, fe_q, pe_q, brk_vis_q, ovr_vis_q, ovr_seen_q;
  logic            ovr_pend_q, brk_pend_q;

  wire par_on   = (pmode_q == 2'b01) || (pmode_q == 2'b10);
  wire mid      = tick16_i && (cnt_q == FULL);
  wire par_x    = (^sh_q) ^ par_q;
  wire par_bad  = (pmode_q == 2'b01) ? par_x : ~par_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pmode_q <= '0;
    end else if (ctrl_we_i) begin
      en_q    <= ctrl_i[1:0];
      pmode_q <= ctrl_i[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; bitn_q <= '0; sh_q <= '0;
      allz_q <= 1'b0; par_q <= 1'b0;
      done_q <= 1'b0; fe_n_q <= 1'b0; pe_n_q <= 1'b0; brk_n_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick16_i && st_q != S_IDLE && st_q != S_WAITHI) cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        S_IDLE: if (tick16_i && !rx_i) begin
          st_q  <= S_START;
          cnt_q <= '0;
        end
        S_START: if (tick16_i && cnt_q == HALF) begin
          cnt_q <= '0;
          if (!rx_i) begin
            st_q   <= S_DATA;
            bitn_q <= '0;
            allz_q <= 1'b1;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_DATA: if (mid) begin
          sh_q   <= {rx_i, sh_q[DBITS-1:1]};
          allz_q <= allz_q & ~rx_i;
          bitn_q <= bitn_q + 1'b1;
          if (bitn_q == BW'(DBITS-1)) st_q <= par_on ? S_PAR : S_STOP;
        end
        S_PAR: if (mid) begin
          par_q  <= rx_i;
          allz_q <= allz_q & ~rx_i;
          st_q   <= S_STOP;
        end
        S_STOP: if (mid) begin
          done_q  <= 1'b1;
          fe_n_q  <= ~rx_i;
          brk_n_q <= allz_q & ~rx_i;
          pe_n_q  <= par_on & par_bad;
          st_q    <= rx_i ? S_IDLE : S_WAITHI;
        end
        S_WAITHI: if (rx_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  wire rd_plain  = rd_data_i && avail_q && !ovr_pend_q && !ovr_vis_q;
  wire ovr_clear = rd_data_i && ovr_vis_q && ovr_seen_q;
  wire ovr_show  = rd_data_i && ovr_pend_q;
  wire free      = !avail_q || rd_plain || ovr_clear;
  wire load      = done_q && free;
  wire drop      = done_q && !free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; avail_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
      brk_vis_q <= 1'b0; ovr_vis_q <= 1'b0; ovr_seen_q <= 1'b0;
      ovr_pend_q <= 1'b0; brk_pend_q <= 1'b0;
    end else begin
      if (rd_plain || ovr_clear) begin
        avail_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
        brk_vis_q <= 1'b0; ovr_vis_q <= 1'b0; ovr_seen_q <= 1'b0;
      end
      if (ovr_show) begin
        ovr_vis_q  <= 1'b1;
        brk_vis_q  <= brk_pend_q;
        fe_q       <= 1'b0;
        pe_q       <= 1'b0;
        ovr_seen_q <= 1'b0;
      end
      if (rd_stat_i && ovr_vis_q && !ovr_clear) ovr_seen_q <= 1'b1;
      if (drop) ovr_pend_q <= 1'b1;
      else if (ovr_show) ovr_pend_q <= 1'b0;
      brk_pend_q <= (ovr_show ? 1'b0 : brk_pend_q) | (drop & brk_n_q);
      if (load) begin
        hold_q    <= sh_q;
        avail_q   <= 1'b1;
        fe_q      <= fe_n_q;
        pe_q      <= pe_n_q;
        brk_vis_q <= brk_n_q;
        ovr_vis_q <= 1'b0;
      end
    end
  end

  assign data_o   = hold_q;
  assign status_o = {3'b000, pe_q, fe_q, brk_vis_q, ovr_vis_q, avail_q};
  assign irq_o    = (en_q[0] & avail_q) |
                    (en_q[1] & (pe_q | fe_q | brk_vis_q | ovr_vis_q | ovr_pend_q));
endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk #(parameter int DBITS = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_data_i,
  input logic [DBITS-1:0] data_o,
  input logic [7:0]       status_o,
  input logic             irq_o,
  input logic [1:0]       en_q,
  input logic             ovr_pend_q
);
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !rd_data_i) |=> $stable(data_o)); // R7
  AST_OVR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(rd_data_i)); // R8
  AST_OVR_WITH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] |-> status_o[0]); // R8
  AST_OVR_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[1]) |-> $past(rd_data_i)); // R9
  AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && !status_o[1]) |-> status_o[3]); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 2'b00) |-> !irq_o); // R10
  AST_IRQ_PENDING_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pend_q && en_q[1]) |-> irq_o); // R10
endmodule

bind uart_rx_hold uart_rx_hold_chk #(.DBITS(DBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data_i), .data_o(data_o),
  .status_o(status_o), .irq_o(irq_o), .en_q(en_q), .ovr_pend_q(ovr_pend_q));

// File: tb/uart_rx_hold_tb_top.sv
module uart_rx_hold_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 32;

  typedef struct { logic [7:0] d; logic [7:0] st; int req; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0;
  logic ctrl_we = 1'b0, rd_data = 1'b0, rd_stat = 1'b0;
  logic [3:0] ctrl = '0;
  logic [7:0] data_o, status_o;
  logic irq_o;
  logic auto_mon = 1'b0;
  int n_cmp = 0, n_bad = 0;
  exp_t q[$];

  uart_rx_hold dut_i (.clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl), .rd_data_i(rd_data), .rd_stat_i(rd_stat),
    .data_o(data_o), .status_o(status_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic line(input logic v, input int nbits);
    rx = v;
    repeat (nbits * BIT_CLK) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic par_en, input logic par_v, input logic stopv);
    line(1'b0, 1);
    for (int i = 0; i < 8; i++) line(d[i], 1);
    if (par_en) line(par_v, 1);
    line(stopv, 1);
    line(1'b1, 1);
  endtask

  task automatic send(input logic [7:0] d, input logic par_en, input logic par_v,
                      input logic stopv, input logic [7:0] st, input int req);
    exp_t e;
    e.d = d; e.st = st; e.req = req;
    q.push_back(e);
    frame(d, par_en, par_v, stopv);
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    ctrl = c; ctrl_we = 1'b1; @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic pulse_data(); rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; endtask
  task automatic pulse_stat(); rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; endtask

  task automatic drain();
    while (q.size() != 0 || status_o[0]) @(negedge clk);
    @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    if (auto_mon && status_o[0]) begin
      if (q.size() == 0) begin
        check(2, "unexpected character", status_o, 8'h00);
        pulse_data();
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "status", status_o, e.st);
        check(e.req, "data", data_o, e.d);
        pulse_data();
        check(2, "avail after read", {7'b0, status_o[0]}, 8'h00);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(1, "status reset", status_o, 8'h00);
    check(1, "irq reset", {7'b0, irq_o}, 8'h00);
    rst_n = 1'b1;
    line(1'b1, 1);

    // R2 normal characters, no parity
    auto_mon = 1'b1;
    send(8'hA5, 0, 0, 1, 8'h01, 2);
    send(8'h3C, 0, 0, 1, 8'h01, 2);
    send(8'h00, 0, 0, 1, 8'h01, 2);
    send(8'hFF, 0, 0, 1, 8'h01, 2);
    drain();

    // R3 even then odd parity
    set_ctrl(4'b0100);
    send(8'h5A, 1, 1'b0, 1, 8'h01, 3);
    send(8'h5A, 1, 1'b1, 1, 8'h11, 3);
    set_ctrl(4'b1000);
    send(8'h01, 1, 1'b0, 1, 8'h01, 3);
    send(8'h01, 1, 1'b1, 1, 8'h11, 3);
    drain();
    set_ctrl(4'b0000);

    // R4 framing error
    send(8'h81, 0, 0, 0, 8'h09, 4);
    drain();

    // R5 break: line low for more than a character time
    begin
      exp_t e;
      e.d = 8'h00; e.st = 8'h0D; e.req = 5;
      q.push_back(e);
      line(1'b0, 11);
      line(1'b1, 2);
    end
    drain();
    auto_mon = 1'b0;

    // R6 false start
    rx = 1'b0; repeat (6) @(negedge clk);
    line(1'b1, 12);
    check(6, "no char after glitch", status_o, 8'h00);

    // R7 R8 R9 R10 overrun sequence, error irq only
    set_ctrl(4'b0010);
    frame(8'h11, 0, 0, 1);
    check(2, "first byte status", status_o, 8'h01);
    check(10, "irq off for data-only", {7'b0, irq_o}, 8'h00);
    frame(8'h22, 0, 0, 1);
    check(8, "overrun hidden", status_o, 8'h01);
    check(7, "held byte kept", data_o, 8'h11);
    check(10, "irq on pending overrun", {7'b0, irq_o}, 8'h01);
    line(1'b0, 11);
    line(1'b1, 2);
    check(8, "break hidden", status_o, 8'h01);
    check(7, "held byte kept after break", data_o, 8'h11);
    pulse_data();
    check(8, "overrun and break shown", status_o, 8'h07);
    pulse_data();
    check(9, "early data read ignored", status_o, 8'h07);
    pulse_stat();
    check(9, "status read no change", status_o, 8'h07);
    pulse_data();
    check(9, "cleared after status then data", status_o, 8'h00);
    check(10, "irq low after clear", {7'b0, irq_o}, 8'h00);

    // R10 data-available enable
    set_ctrl(4'b0001);
    frame(8'h6B, 0, 0, 1);
    check(10, "irq for byte", {7'b0, irq_o}, 8'h01);
    check(2, "byte value", data_o, 8'h6B);
    pulse_data();
    check(10, "irq drops on read", {7'b0, irq_o}, 8'h00);
    frame(8'h44, 0, 0, 0);
    check(10, "framing with error irq off", {7'b0, irq_o}, 8'h01);
    set_ctrl(4'b0000);
    check(10, "all enables off", {7'b0, irq_o}, 8'h00);
    pulse_data();
    check(4, "framing cleared", status_o, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule